// File: doc/BRIEF.md
# Condition Flag Evaluation Unit

This unit keeps the four result flags of a processor core (negative, zero, carry, overflow) and decides, for every instruction presented to it, whether that instruction is allowed to execute. The decode stage supplies a 4-bit condition code together with the instruction. The unit compares that code against the stored flags and drives a combinational execute-enable.

When an instruction is valid, passes its condition and asks for a flag update, the new flags produced by the ALU are captured on the next clock edge. A conditional instruction can therefore also set flags. An instruction that fails its condition leaves the flags untouched, even when it asks for an update. The flag bundle is ordered negative, zero, carry, overflow from bit 3 down to bit 0.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst` is high on a clock edge, all four flags are cleared to 0 after that edge.
- R2: Code 1110 (always) drives `exec_o` high for every flag combination.
- R3: Code 0000 executes exactly when Z is 1, and code 0001 exactly when Z is 0.
- R4: Code 0100 executes exactly when N is 1, and code 0101 exactly when N is 0.
- R5: Code 1010 executes when N equals V, and code 1011 when N differs from V.
- R6: Code 1100 executes when Z is 0 and N equals V, and code 1101 when Z is 1 or N differs from V.
- R7: The codes 0010, 0011, 0110, 0111, 1000, 1001 and 1111 never execute.
- R8: On a clock edge where `valid_i`, `exec_o` and `set_flags_i` are all high, the flags take the value of `alu_flags_i` (bit 3 N, bit 2 Z, bit 1 C, bit 0 V).
- R9: On a clock edge where the condition fails, the flags keep their value, even when `set_flags_i` and `valid_i` are high.
- R10: On a clock edge where `set_flags_i` is low or `valid_i` is low, the flags keep their value.
- R11: `exec_o` is combinational from `cond_i` and the flags. In the cycle after an update it already reflects the new flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | An instruction is presented this cycle |
| cond_i | input | 4 | Condition code of the instruction |
| set_flags_i | input | 1 | Instruction requests a flag update |
| alu_flags_i | input | 4 | New flags from the ALU, {N,Z,C,V} |
| exec_o | output | 1 | Instruction passes its condition |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |

## Verification
Condition evaluation and flag update coincide whenever a flag-setting instruction is conditional. Its own pass or fail, computed from the old flags, must gate the write of the new ones. The bench presets every one of the 16 flag states and then offers each of the 16 codes with an update request, both valid and invalid. The ALU value offered is the bitwise inverse of the stored flags, so any wrongly accepted or wrongly refused write changes every flag bit. After the edge the bench compares the flags with an arithmetic model: the new value where the condition passed, the old value otherwise.

// File: rtl/cond_flag_pkg.sv
`timescale 1ns/1ps
package cond_flag_pkg;
    localparam int COND_W = 4;
    localparam int FLAG_W = 4;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        CC_EQ = 4'b0000,
        CC_NE = 4'b0001,
        CC_MI = 4'b0100,
        CC_PL = 4'b0101,
        CC_GE = 4'b1010,
        CC_LT = 4'b1011,
        CC_GT = 4'b1100,
        CC_LE = 4'b1101,
        CC_AL = 4'b1110
    } cc_e;

    // Signed-compare helper: N and V agree
    function automatic logic sign_ok(flags_t f);
        return f.neg == f.ovf;
    endfunction

    function automatic logic cc_holds(logic [COND_W-1:0] code, flags_t f);
        logic r;
        case (code)
            CC_EQ:   r = f.zero;
            CC_NE:   r = !f.zero;
            CC_MI:   r = f.neg;
            CC_PL:   r = !f.neg;
            CC_GE:   r = sign_ok(f);
            CC_LT:   r = !sign_ok(f);
            CC_GT:   r = !f.zero && sign_ok(f);
            CC_LE:   r = f.zero || !sign_ok(f);
            CC_AL:   r = 1'b1;
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/cc_eval.sv
`timescale 1ns/1ps
module cc_eval
    import cond_flag_pkg::*;
(
    input  logic [COND_W-1:0] code_i,
    input  flags_t            flags_i,
    output logic              pass_o
);
    always_comb begin
        pass_o = cc_holds(code_i, flags_i);
    end
endmodule

// File: rtl/flag_reg.sv
`timescale 1ns/1ps
module flag_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst)
            q_o <= '0;
        else if (load_i)
            q_o <= d_i;
    end
endmodule

// File: rtl/cond_flag_unit.sv
`timescale 1ns/1ps
module cond_flag_unit
    import cond_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              set_flags_i,
    input  logic [FLAG_W-1:0] alu_flags_i,
    output logic              exec_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              flag_v_o
);
    flags_t cur_flags;
    flags_t new_flags;
    logic   pass;
    logic   write_en;

    assign new_flags = flags_t'(alu_flags_i);

    cc_eval u_eval (
        .code_i  (cond_i),
        .flags_i (cur_flags),
        .pass_o  (pass)
    );

    // A write needs a valid instruction that passed and asked for it
    assign write_en = valid_i && pass && set_flags_i;

    flag_reg #(.W(FLAG_W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .load_i (write_en),
        .d_i    (new_flags),
        .q_o    (cur_flags)
    );

    assign exec_o   = pass;
    assign flag_n_o = cur_flags.neg;
    assign flag_z_o = cur_flags.zero;
    assign flag_c_o = cur_flags.carry;
    assign flag_v_o = cur_flags.ovf;
endmodule

// File: rtl/cond_flag_checker.sv
`timescale 1ns/1ps
module cond_flag_checker (
    input logic       clk,
    input logic       rst,
    input logic       valid_i,
    input logic [3:0] cond_i,
    input logic       set_flags_i,
    input logic [3:0] alu_flags_i,
    input logic       exec_o,
    input logic       flag_n_o,
    input logic       flag_z_o,
    input logic       flag_c_o,
    input logic       flag_v_o
);
    logic [3:0] fl;
    assign fl = {flag_n_o, flag_z_o, flag_c_o, flag_v_o};

    logic bad_code;
    assign bad_code = (cond_i == 4'b0010) || (cond_i == 4'b0011) ||
                      (cond_i == 4'b0110) || (cond_i == 4'b0111) ||
                      (cond_i == 4'b1000) || (cond_i == 4'b1001) ||
                      (cond_i == 4'b1111);

    assert_always_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'b1110) |-> exec_o);

    assert_eq_follows_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (cond_i == 4'b0000) |-> (exec_o == flag_z_o));

    assert_unused_code_blocked_R7: assert property (@(posedge clk) disable iff (rst)
        bad_code |-> !exec_o);

    assert_flags_loaded_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && exec_o && set_flags_i) |=> (fl == $past(alu_flags_i)));

    assert_failed_cond_keeps_R9: assert property (@(posedge clk) disable iff (rst)
        (!exec_o) |=> $stable(fl));

    assert_no_request_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (!valid_i || !set_flags_i) |=> $stable(fl));
endmodule

bind cond_flag_unit cond_flag_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (valid_i),
    .cond_i      (cond_i),
    .set_flags_i (set_flags_i),
    .alu_flags_i (alu_flags_i),
    .exec_o      (exec_o),
    .flag_n_o    (flag_n_o),
    .flag_z_o    (flag_z_o),
    .flag_c_o    (flag_c_o),
    .flag_v_o    (flag_v_o)
);

// File: tb/test_cond_flag_unit.sv
`timescale 1ns/1ps
module test_cond_flag_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       valid_i;
    logic [3:0] cond_i;
    logic       set_flags_i;
    logic [3:0] alu_flags_i;
    logic       exec_o;
    logic       flag_n_o, flag_z_o, flag_c_o, flag_v_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (
        .clk         (clk),
        .rst         (rst),
        .valid_i     (valid_i),
        .cond_i      (cond_i),
        .set_flags_i (set_flags_i),
        .alu_flags_i (alu_flags_i),
        .exec_o      (exec_o),
        .flag_n_o    (flag_n_o),
        .flag_z_o    (flag_z_o),
        .flag_c_o    (flag_c_o),
        .flag_v_o    (flag_v_o)
    );

    function automatic logic [3:0] cur();
        return {flag_n_o, flag_z_o, flag_c_o, flag_v_o};
    endfunction

    // Independent model: f = {N,Z,C,V}
    function automatic logic model_pass(logic [3:0] code, logic [3:0] f);
        logic n, z, v;
        n = f[3]; z = f[2]; v = f[0];
        case (code)
            4'd0:  return z;
            4'd1:  return ~z;
            4'd4:  return n;
            4'd5:  return ~n;
            4'd10: return (n ^ v) == 1'b0;
            4'd11: return (n ^ v) == 1'b1;
            4'd12: return (z == 1'b0) && ((n ^ v) == 1'b0);
            4'd13: return z || (n ^ v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [3:0] code);
        case (code)
            4'd0, 4'd1:   return "R3";
            4'd4, 4'd5:   return "R4";
            4'd10, 4'd11: return "R5";
            4'd12, 4'd13: return "R6";
            4'd14:        return "R2";
            default:      return "R7";
        endcase
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Preset flags with an always-executing, flag-setting instruction
    task automatic load(logic [3:0] f);
        @(negedge clk);
        valid_i = 1; cond_i = 4'b1110; set_flags_i = 1; alu_flags_i = f;
        @(negedge clk);
        valid_i = 0; set_flags_i = 0;
        check("R8", cur(), f);
    endtask

    initial begin
        rst = 1; valid_i = 0; cond_i = 4'b1110; set_flags_i = 0; alu_flags_i = 4'hF;
        repeat (2) @(negedge clk);
        check("R1", cur(), 4'h0);
        rst = 0;
        @(negedge clk);
        check("R10", cur(), 4'h0);

        for (int old = 0; old < 16; old++) begin
            for (int code = 0; code < 16; code++) begin
                for (int mode = 0; mode < 4; mode++) begin
                    logic v, s, p;
                    logic [3:0] expf;
                    v = mode[1];
                    s = mode[0];
                    load(4'(old));
                    valid_i = v; set_flags_i = s; cond_i = 4'(code);
                    alu_flags_i = ~4'(old);
                    #1;
                    p = model_pass(4'(code), 4'(old));
                    check(tag_of(4'(code)), {3'b0, exec_o}, {3'b0, p});
                    @(negedge clk);
                    valid_i = 0; set_flags_i = 0;
                    expf = (v && s && p) ? ~4'(old) : 4'(old);
                    if (v && s)
                        check(p ? "R8" : "R9", cur(), expf);
                    else
                        check("R10", cur(), expf);
                    // R11: exec reflects the flags held after this edge
                    #1;
                    check("R11", {3'b0, exec_o}, {3'b0, model_pass(4'(code), expf)});
                end
            end
        end

        // Reset in mid-run clears flags again
        load(4'hF);
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1", cur(), 4'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule